// File: doc/BRIEF.md
# Branch and Next-PC Unit

This block works out where instruction fetch goes next in a 16-bit processor whose instructions each fill two consecutive byte cells. Each cycle it may receive one instruction, together with that instruction's fetch address and the two register values named by the instruction's register fields. One clock later it returns the next program counter and a flag that says whether control flow left the sequential path. For a subroutine call it also returns a register write request that carries the return address.

The block handles four conditional branches that test a register for zero, non-zero, sign clear or sign set. It handles an unconditional jump whose base depends on its register field. A field of zero gives a jump relative to the PC. Any other field gives a jump relative to that register. It also handles a call that saves the return address in a general register, and a return that loads the PC from a register. Relative targets and the saved return address are based on the address of the following instruction, which is the fetch address plus 2. All PC arithmetic wraps modulo 2^16.

Top module: `nxp_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `out_valid`, `taken` and `link_we` are 0 and `next_pc` is 0.
- R2: A result appears on the outputs exactly one clock edge after the edge that samples `in_valid` high, with `out_valid` high for that one cycle. When `in_valid` was low, `out_valid`, `taken` and `link_we` are 0.
- R3: The opcode is `instr[15:11]`. Any opcode other than 16, 17, 18, 19, 20, 22 and 23 gives `next_pc` = `pc` + 2, `taken` = 0 and `link_we` = 0.
- R4: Opcode 19 (branch on zero) is taken when `ra_data` equals 0. Opcode 18 (branch on non-zero) is taken when `ra_data` is not 0.
- R5: Opcode 16 (branch on plus) is taken when bit 15 of `ra_data` is 0, and this includes the value zero. Opcode 17 (branch on minus) is taken when bit 15 is 1.
- R6: A conditional branch that is taken gives `next_pc` = `pc` + 2 + sext(`instr[7:0]`) and `taken` = 1. One that is not taken gives `next_pc` = `pc` + 2 and `taken` = 0. Neither case writes the link register.
- R7: Opcode 20 with the register field `instr[10:8]` equal to 0 gives `next_pc` = `pc` + 2 + sext(`instr[7:0]`) and `taken` = 1.
- R8: Opcode 20 with a non-zero register field gives `next_pc` = `ra_data` + sext(`instr[7:0]`) and `taken` = 1. This holds even when `ra_data` itself is 0.
- R9: Opcode 22 (call) gives `next_pc` = `rb_data` and `taken` = 1. It also gives `link_we` = 1, `link_addr` = `instr[10:8]` and `link_data` = `pc` + 2. The second register operand sits in `instr[7:5]`.
- R10: Opcode 23 (return) gives `next_pc` = `ra_data` and `taken` = 1, with `link_we` = 0.
- R11: The 8-bit displacement is sign-extended, so it covers -128 to +127. The value 0x80 moves 128 bytes back and 0x7F moves 127 bytes forward.
- R12: All target and return-address sums wrap modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| pc | input | 16 | Fetch address of the presented instruction |
| instr | input | 16 | Instruction word |
| ra_data | input | 16 | Value of the register named in `instr[10:8]` |
| rb_data | input | 16 | Value of the register named in `instr[7:5]` |
| out_valid | output | 1 | Result of the instruction sampled on the previous edge |
| next_pc | output | 16 | Address to fetch next |
| taken | output | 1 | Control flow left the sequential path |
| link_we | output | 1 | Write the return address to a register |
| link_addr | output | 3 | Register index for the return address |
| link_data | output | 16 | Return address |

## Verification
Every result of this block is due on the first rising edge after the edge that samples the instruction, and a new instruction can follow on each cycle. The driver sets inputs on a falling edge and queues the result it expects. On each later falling edge where `out_valid` is high, the monitor takes the oldest queued entry and compares it. Each comparison therefore lands exactly one cycle after its stimulus. A result that arrives with nothing queued, or a queue that still holds entries after the final idle cycles, counts as a latency failure.

// File: rtl/nxp_pkg.sv
package nxp_pkg;

    localparam int unsigned WORD_W      = 16;
    localparam int unsigned OPC_W       = 5;
    localparam int unsigned RIDX_W      = 3;
    localparam int unsigned DISP_W      = 8;
    localparam int unsigned INSTR_BYTES = 2;

    localparam logic [OPC_W-1:0] OPC_BR_PLUS  = 5'd16;
    localparam logic [OPC_W-1:0] OPC_BR_MINUS = 5'd17;
    localparam logic [OPC_W-1:0] OPC_BR_NZERO = 5'd18;
    localparam logic [OPC_W-1:0] OPC_BR_ZERO  = 5'd19;
    localparam logic [OPC_W-1:0] OPC_JMP      = 5'd20;
    localparam logic [OPC_W-1:0] OPC_CALL     = 5'd22;
    localparam logic [OPC_W-1:0] OPC_RET      = 5'd23;

    typedef enum logic [2:0] {
        FLOW_SEQ,
        FLOW_COND,
        FLOW_JUMP,
        FLOW_CALL,
        FLOW_RET
    } flow_e;

    typedef enum logic [1:0] {
        TEST_ZERO,
        TEST_NONZERO,
        TEST_PLUS,
        TEST_MINUS
    } test_e;

    typedef struct packed {
        flow_e             flow;
        test_e             test;
        logic [RIDX_W-1:0] ra_idx;
        logic              ra_field_zero;
    } dec_t;

endpackage

// File: rtl/nxp_decode.sv
module nxp_decode
    import nxp_pkg::*;
#(
    parameter int unsigned INSTR_W = nxp_pkg::WORD_W,
    parameter int unsigned PC_W    = nxp_pkg::WORD_W
) (
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec,
    output logic [PC_W-1:0]    disp_ext
);

    localparam int unsigned OPC_LSB = INSTR_W - OPC_W;
    localparam int unsigned RA_LSB  = OPC_LSB - RIDX_W;

    logic [OPC_W-1:0]  opc;
    logic [RIDX_W-1:0] ra_f;
    logic [DISP_W-1:0] c2;

    assign opc  = instr[OPC_LSB +: OPC_W];
    assign ra_f = instr[RA_LSB +: RIDX_W];
    assign c2   = instr[DISP_W-1:0];

    generate
        if (PC_W > DISP_W) begin : g_sext
            assign disp_ext = {{(PC_W-DISP_W){c2[DISP_W-1]}}, c2};
        end else begin : g_trunc
            assign disp_ext = c2[PC_W-1:0];
        end
    endgenerate

    always_comb begin
        dec.flow          = FLOW_SEQ;
        dec.test          = TEST_ZERO;
        dec.ra_idx        = ra_f;
        dec.ra_field_zero = (ra_f == '0);
        unique case (opc)
            OPC_BR_ZERO: begin
                dec.flow = FLOW_COND;
                dec.test = TEST_ZERO;
            end
            OPC_BR_NZERO: begin
                dec.flow = FLOW_COND;
                dec.test = TEST_NONZERO;
            end
            OPC_BR_PLUS: begin
                dec.flow = FLOW_COND;
                dec.test = TEST_PLUS;
            end
            OPC_BR_MINUS: begin
                dec.flow = FLOW_COND;
                dec.test = TEST_MINUS;
            end
            OPC_JMP:  dec.flow = FLOW_JUMP;
            OPC_CALL: dec.flow = FLOW_CALL;
            OPC_RET:  dec.flow = FLOW_RET;
            default:  dec.flow = FLOW_SEQ;
        endcase
    end

endmodule

// File: rtl/nxp_cond.sv
module nxp_cond
    import nxp_pkg::*;
#(
    parameter int unsigned PC_W = nxp_pkg::WORD_W
) (
    input  logic [PC_W-1:0] value,
    input  test_e           test,
    output logic            hit
);

    logic is_zero;
    logic is_neg;

    assign is_zero = (value == '0);
    assign is_neg  = value[PC_W-1];

    always_comb begin
        unique case (test)
            TEST_ZERO:    hit = is_zero;
            TEST_NONZERO: hit = !is_zero;
            TEST_PLUS:    hit = !is_neg;
            TEST_MINUS:   hit = is_neg;
            default:      hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/nxp_target.sv
module nxp_target
    import nxp_pkg::*;
#(
    parameter int unsigned PC_W = nxp_pkg::WORD_W
) (
    input  logic [PC_W-1:0] pc,
    input  logic [PC_W-1:0] ra_data,
    input  logic [PC_W-1:0] rb_data,
    input  logic [PC_W-1:0] disp_ext,
    input  dec_t            dec,
    input  logic            cond_hit,
    output logic [PC_W-1:0] target,
    output logic            taken,
    output logic            link_we,
    output logic [PC_W-1:0] ret_addr
);

    localparam logic [PC_W-1:0] STEP = PC_W'(INSTR_BYTES);

    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] base;
    logic [PC_W-1:0] rel_pc;

    assign seq_pc   = pc + STEP;
    assign base     = (dec.flow == FLOW_JUMP && !dec.ra_field_zero) ? ra_data : seq_pc;
    assign rel_pc   = base + disp_ext;
    assign ret_addr = seq_pc;

    always_comb begin
        target  = seq_pc;
        taken   = 1'b0;
        link_we = 1'b0;
        unique case (dec.flow)
            FLOW_COND: begin
                if (cond_hit) begin
                    target = rel_pc;
                    taken  = 1'b1;
                end
            end
            FLOW_JUMP: begin
                target = rel_pc;
                taken  = 1'b1;
            end
            FLOW_CALL: begin
                target  = rb_data;
                taken   = 1'b1;
                link_we = 1'b1;
            end
            FLOW_RET: begin
                target = ra_data;
                taken  = 1'b1;
            end
            default: begin
                target = seq_pc;
            end
        endcase
    end

endmodule

// File: rtl/nxp_unit.sv
module nxp_unit
    import nxp_pkg::*;
#(
    parameter int unsigned PC_W    = nxp_pkg::WORD_W,
    parameter int unsigned INSTR_W = nxp_pkg::WORD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [PC_W-1:0]    pc,
    input  logic [INSTR_W-1:0] instr,
    input  logic [PC_W-1:0]    ra_data,
    input  logic [PC_W-1:0]    rb_data,
    output logic               out_valid,
    output logic [PC_W-1:0]    next_pc,
    output logic               taken,
    output logic               link_we,
    output logic [RIDX_W-1:0]  link_addr,
    output logic [PC_W-1:0]    link_data
);

    typedef struct packed {
        logic              valid;
        logic [PC_W-1:0]   npc;
        logic              taken;
        logic              link_we;
        logic [RIDX_W-1:0] link_addr;
        logic [PC_W-1:0]   link_data;
    } res_t;

    dec_t            dec;
    logic [PC_W-1:0] disp_ext;
    logic            cond_hit;
    logic [PC_W-1:0] tgt;
    logic            tgt_taken;
    logic            tgt_link;
    logic [PC_W-1:0] ret_addr;

    res_t res_d;
    res_t res_q;

    nxp_decode #(
        .INSTR_W (INSTR_W),
        .PC_W    (PC_W)
    ) u_decode (
        .instr    (instr),
        .dec      (dec),
        .disp_ext (disp_ext)
    );

    nxp_cond #(
        .PC_W (PC_W)
    ) u_cond (
        .value (ra_data),
        .test  (dec.test),
        .hit   (cond_hit)
    );

    nxp_target #(
        .PC_W (PC_W)
    ) u_target (
        .pc       (pc),
        .ra_data  (ra_data),
        .rb_data  (rb_data),
        .disp_ext (disp_ext),
        .dec      (dec),
        .cond_hit (cond_hit),
        .target   (tgt),
        .taken    (tgt_taken),
        .link_we  (tgt_link),
        .ret_addr (ret_addr)
    );

    always_comb begin
        res_d         = res_q;
        res_d.valid   = 1'b0;
        res_d.taken   = 1'b0;
        res_d.link_we = 1'b0;
        if (in_valid) begin
            res_d.valid     = 1'b1;
            res_d.npc       = tgt;
            res_d.taken     = tgt_taken;
            res_d.link_we   = tgt_link;
            res_d.link_addr = dec.ra_idx;
            res_d.link_data = ret_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid = res_q.valid;
    assign next_pc   = res_q.npc;
    assign taken     = res_q.taken;
    assign link_we   = res_q.link_we;
    assign link_addr = res_q.link_addr;
    assign link_data = res_q.link_data;

endmodule

// File: rtl/nxp_unit_chk.sv
module nxp_unit_chk
    import nxp_pkg::*;
#(
    parameter int unsigned PC_W    = nxp_pkg::WORD_W,
    parameter int unsigned INSTR_W = nxp_pkg::WORD_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [PC_W-1:0]    pc,
    input logic [INSTR_W-1:0] instr,
    input logic [PC_W-1:0]    ra_data,
    input logic [PC_W-1:0]    rb_data,
    input logic               out_valid,
    input logic [PC_W-1:0]    next_pc,
    input logic               taken,
    input logic               link_we,
    input logic [RIDX_W-1:0]  link_addr,
    input logic [PC_W-1:0]    link_data
);

    localparam int unsigned   OPC_LSB = INSTR_W - OPC_W;
    localparam int unsigned   RA_LSB  = OPC_LSB - RIDX_W;
    localparam logic [PC_W-1:0] STEP  = PC_W'(INSTR_BYTES);

    logic                past_ok;
    logic [OPC_W-1:0]    opc;
    logic [RIDX_W-1:0]   ra_f;
    logic [PC_W-1:0]     disp_now;
    logic                is_seq;

    assign opc      = instr[OPC_LSB +: OPC_W];
    assign ra_f     = instr[RA_LSB +: RIDX_W];
    assign disp_now = {{(PC_W-DISP_W){instr[DISP_W-1]}}, instr[DISP_W-1:0]};
    assign is_seq   = !(opc inside {OPC_BR_PLUS, OPC_BR_MINUS, OPC_BR_NZERO,
                                    OPC_BR_ZERO, OPC_JMP, OPC_CALL, OPC_RET});

    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    p_valid_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (out_valid == $past(in_valid)));

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!taken && !link_we));

    p_link_only_call_r9: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (out_valid && taken));

    p_seq_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(in_valid && is_seq)) |->
            (next_pc == $past(pc) + STEP && !taken && !link_we));

    p_call_link_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(in_valid && opc == OPC_CALL)) |->
            (link_we && link_addr == $past(ra_f) &&
             link_data == $past(pc) + STEP && next_pc == $past(rb_data)));

    p_ret_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(in_valid && opc == OPC_RET)) |->
            (taken && !link_we && next_pc == $past(ra_data)));

    p_near_jump_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(in_valid && opc == OPC_JMP && ra_f == '0)) |->
            (taken && next_pc == $past(pc) + STEP + $past(disp_now)));

endmodule

bind nxp_unit nxp_unit_chk #(.PC_W(PC_W), .INSTR_W(INSTR_W)) u_chk (.*);

// File: tb/nxp_unit_tb.sv
module nxp_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [15:0] pc;
    logic [15:0] instr;
    logic [15:0] ra_data;
    logic [15:0] rb_data;
    logic        out_valid;
    logic [15:0] next_pc;
    logic        taken;
    logic        link_we;
    logic [2:0]  link_addr;
    logic [15:0] link_data;

    always #4 clk = ~clk;

    nxp_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .pc        (pc),
        .instr     (instr),
        .ra_data   (ra_data),
        .rb_data   (rb_data),
        .out_valid (out_valid),
        .next_pc   (next_pc),
        .taken     (taken),
        .link_we   (link_we),
        .link_addr (link_addr),
        .link_data (link_data)
    );

    typedef struct packed {
        logic [15:0] npc;
        logic        tk;
        logic        we;
        logic [2:0]  la;
        logic [15:0] ld;
    } exp_t;

    exp_t  sb_q[$];
    string tag_q[$];
    int    checks = 0;
    int    fails  = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [15:0] p, input logic [15:0] ins,
                                   input logic [15:0] a, input logic [15:0] b);
        exp_t        e;
        logic [4:0]  op;
        logic [2:0]  rf;
        logic [15:0] nxt;
        logic [15:0] d;
        op  = ins[15:11];
        rf  = ins[10:8];
        nxt = p + 16'd2;
        d   = {{8{ins[7]}}, ins[7:0]};
        e   = '0;
        e.npc = nxt;
        case (op)
            5'd19: if (a == 16'd0) begin e.tk = 1'b1; e.npc = nxt + d; end
            5'd18: if (a != 16'd0) begin e.tk = 1'b1; e.npc = nxt + d; end
            5'd16: if (!a[15])     begin e.tk = 1'b1; e.npc = nxt + d; end
            5'd17: if (a[15])      begin e.tk = 1'b1; e.npc = nxt + d; end
            5'd20: begin
                e.tk  = 1'b1;
                e.npc = (rf == 3'd0) ? nxt + d : a + d;
            end
            5'd22: begin
                e.tk  = 1'b1;
                e.npc = b;
                e.we  = 1'b1;
                e.la  = rf;
                e.ld  = nxt;
            end
            5'd23: begin
                e.tk  = 1'b1;
                e.npc = a;
            end
            default: ;
        endcase
        return e;
    endfunction

    task automatic issue(input logic [15:0] p, input logic [15:0] ins,
                         input logic [15:0] a, input logic [15:0] b, input string req);
        @(negedge clk);
        in_valid = 1'b1;
        pc       = p;
        instr    = ins;
        ra_data  = a;
        rb_data  = b;
        sb_q.push_back(model(p, ins, a, b));
        tag_q.push_back(req);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            pc       = 16'hDEAD;
            instr    = 16'hA5A5;
        end
    endtask

    function automatic logic [15:0] enc2(input logic [4:0] op, input logic [2:0] r,
                                         input logic [7:0] c);
        return {op, r, c};
    endfunction

    always @(negedge clk) begin
        if (rst_n === 1'b1 && out_valid === 1'b1) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R2", "result without stimulus", 32'(out_valid), 32'd0);
            end else begin
                exp_t  e;
                string t;
                e = sb_q.pop_front();
                t = tag_q.pop_front();
                check(next_pc === e.npc, t, "next_pc", 32'(next_pc), 32'(e.npc));
                check(taken === e.tk, t, "taken", 32'(taken), 32'(e.tk));
                check(link_we === e.we, t, "link_we", 32'(link_we), 32'(e.we));
                if (e.we) begin
                    check(link_addr === e.la, t, "link_addr", 32'(link_addr), 32'(e.la));
                    check(link_data === e.ld, t, "link_data", 32'(link_data), 32'(e.ld));
                end
            end
        end
    end

    initial begin
        #(8 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        pc       = '0;
        instr    = '0;
        ra_data  = '0;
        rb_data  = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid === 1'b0, "R1", "out_valid in reset", 32'(out_valid), 32'd0);
        check(taken === 1'b0, "R1", "taken in reset", 32'(taken), 32'd0);
        check(link_we === 1'b0, "R1", "link_we in reset", 32'(link_we), 32'd0);
        check(next_pc === 16'd0, "R1", "next_pc in reset", 32'(next_pc), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid === 1'b0, "R1", "out_valid after reset", 32'(out_valid), 32'd0);

        // R3: sequential opcodes (nop 21, add 0, move-immediate 7, halt 31)
        issue(16'h0100, enc2(5'd21, 3'd0, 8'h00), 16'h0000, 16'h0000, "R3");
        issue(16'h0200, enc2(5'd0,  3'd4, 8'h65), 16'h0000, 16'h1111, "R3");
        issue(16'h0300, enc2(5'd7,  3'd3, 8'h38), 16'h8000, 16'h0000, "R3");
        issue(16'h0310, enc2(5'd31, 3'd7, 8'hFF), 16'hFFFF, 16'hFFFF, "R3");

        // R4 / R6: zero and non-zero tests, both outcomes
        issue(16'h0400, enc2(5'd19, 3'd3, 8'h04), 16'h0000, 16'h0000, "R4");
        issue(16'h0400, enc2(5'd19, 3'd3, 8'h04), 16'h0001, 16'h0000, "R6");
        issue(16'h0500, enc2(5'd18, 3'd4, 8'h10), 16'h8000, 16'h0000, "R4");
        issue(16'h0500, enc2(5'd18, 3'd4, 8'h10), 16'h0000, 16'h0000, "R6");

        // R5: sign tests on bit 15, zero counts as plus
        issue(16'h0600, enc2(5'd16, 3'd1, 8'hF0), 16'h7FFF, 16'h0000, "R5");
        issue(16'h0600, enc2(5'd16, 3'd1, 8'hF0), 16'h0000, 16'h0000, "R5");
        issue(16'h0600, enc2(5'd16, 3'd1, 8'hF0), 16'h8000, 16'h0000, "R5");
        issue(16'h0700, enc2(5'd17, 3'd7, 8'h08), 16'h8000, 16'h0000, "R5");
        issue(16'h0700, enc2(5'd17, 3'd7, 8'h08), 16'h0001, 16'h0000, "R5");
        idle(2);
        // R2: no result once the stream stops
        check(out_valid === 1'b0, "R2", "out_valid when idle", 32'(out_valid), 32'd0);
        check(taken === 1'b0, "R2", "taken when idle", 32'(taken), 32'd0);

        // R7 / R11: PC-relative jump, displacement extremes
        issue(16'h0200, enc2(5'd20, 3'd0, 8'h80), 16'h5555, 16'h0000, "R11");
        issue(16'h0200, enc2(5'd20, 3'd0, 8'h7F), 16'h5555, 16'h0000, "R11");
        issue(16'h0A00, enc2(5'd20, 3'd0, 8'h06), 16'h0000, 16'h0000, "R7");

        // R8: register-relative jump, including a zero register value
        issue(16'h0A00, enc2(5'd20, 3'd3, 8'hFE), 16'h1000, 16'h0000, "R8");
        issue(16'h0A00, enc2(5'd20, 3'd5, 8'h04), 16'h0000, 16'h0000, "R8");

        // R9: call with link write; R10: return
        issue(16'h0400, {5'd22, 3'd4, 3'd3, 5'd0}, 16'h2222, 16'h3000, "R9");
        issue(16'h0800, {5'd22, 3'd6, 3'd1, 5'd0}, 16'h0000, 16'h4444, "R9");
        issue(16'h3002, enc2(5'd23, 3'd4, 8'h00), 16'h0402, 16'h9999, "R10");
        issue(16'h3002, enc2(5'd23, 3'd7, 8'h00), 16'h1234, 16'h0000, "R10");

        // R12: wrap-around of every sum
        issue(16'hFFFE, enc2(5'd21, 3'd0, 8'h00), 16'h0000, 16'h0000, "R12");
        issue(16'hFFFC, enc2(5'd20, 3'd0, 8'h10), 16'h0000, 16'h0000, "R12");
        issue(16'hFFF0, enc2(5'd20, 3'd2, 8'h20), 16'hFFF0, 16'h0000, "R12");
        issue(16'h0000, enc2(5'd19, 3'd2, 8'hF0), 16'h0000, 16'h0000, "R12");
        issue(16'hFFFE, {5'd22, 3'd1, 3'd2, 5'd0}, 16'h0000, 16'h0100, "R12");
        idle(3);
        // R2: every queued result was delivered
        check(sb_q.size() == 0, "R2", "results outstanding", 32'(sb_q.size()), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule